// File: doc/BRIEF.md
# Supervisor Address-Translation Control Register

This block is the 32-bit control register that a supervisor kernel writes to switch address spaces. It holds three fields: a one-bit paging mode, an address-space identifier (ASID), and the physical page number (PPN) of the root page table. From this state and the hart's effective privilege level it derives one signal: whether memory accesses are translated right now. It also drives the current ASID and the root PPN to the translation hardware.

Illegal writes are legalized at build time. A parameter states whether the paged mode exists at all. A write that asks for a mode the hart lacks is discarded as a whole. A second parameter sets how many ASID bits are real, from zero to nine. Software finds that width by writing ones to the field and reading it back.

New field values drive the outputs on the cycle after the write, with no fence. Writing the register never flushes cached translations and never orders earlier page-table stores; that work belongs to other logic. For debug and monitoring, a one-cycle pulse marks every write that changes the mode or the ASID.

Top module: `xlat_ctrl_top`

## Requirements
- R1: The register layout is mode at bit 31 (0 = Bare, 1 = paged), ASID at bits 30:22 and root PPN at bits 21:0. A write is taken when csrWrEn is high at a rising clock edge, and csrRdData shows the result from the next cycle on.
- R2: xlatEn is high exactly when the stored mode is 1 and privLvl is 2'b00 (user) or 2'b01 (supervisor). With privLvl 2'b11 (machine) or 2'b10, xlatEn is low.
- R3: When PAGED_EN is 0, a write with bit 31 set is ignored entirely and no field changes. A write with bit 31 clear is still taken.
- R4: Only the low ASID_W bits of the ASID field are stored. The upper ASID bits read as zero and ignore writes. With ASID_W = 0 the whole field reads as zero.
- R5: curAsid, rootPpn and xlatEn follow the new register value in the cycle after the write, with no further action.
- R6: ctxChgPulse is high for exactly the cycle in which a taken write's values first appear, and only if that write changed the mode or the stored ASID. A write that changes only the PPN, or rewrites the same value, gives no pulse.
- R7: In any cycle without a write, the register contents do not change.
- R8: After reset, the register reads zero, xlatEn is low and ctxChgPulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Write strobe |
| csrWrData | input | 32 | Write value |
| csrRdData | output | 32 | Current register value |
| privLvl | input | 2 | Effective privilege (00 user, 01 supervisor, 11 machine) |
| xlatEn | output | 1 | Translation active |
| curAsid | output | 9 | Current ASID, zero-extended |
| rootPpn | output | 22 | Root page-table PPN |
| ctxChgPulse | output | 1 | One-cycle pulse on a mode or ASID change |

## Verification
The assertions check on every cycle that:
- the register holds its value when there is no write;
- unimplemented ASID bits stay zero;
- an unsupported mode never appears in the register;
- a machine-level privilege never sees translation;
- the ASID and PPN outputs match the readback;
- the change pulse fires exactly when the mode or ASID moved.

Only the bench's scenarios can show the rest:
- every write value lands in the correct field;
- the ASID width can be found by writing ones;
- a whole write carrying an illegal mode is discarded, PPN included;
- PPN-only changes and identical rewrites give no pulse.

The bench sweeps all ASID values and every privilege code on two builds, one with paging and four ASID bits, one without paging and with no ASID bits.

// File: rtl/xlat_ctrl_pkg.sv
package xlat_ctrl_pkg;
  localparam int MODE_BIT = 31;
  localparam int ASID_LSB = 22;
  localparam int ASID_MAX = 9;
  localparam int PPN_W    = 22;

  typedef struct packed {
    logic load;  // commit the legalized write
    logic chg;   // committed write moves mode or ASID
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl_ctl.sv
module xlat_ctrl_ctl
  import xlat_ctrl_pkg::*;
#(
  parameter bit PAGED_EN = 1'b1
) (
  input  logic                csrWrEn,
  input  logic                wrMode,
  input  logic [ASID_MAX-1:0] wrAsidLegal,
  input  logic                curMode,
  input  logic [ASID_MAX-1:0] curAsidQ,
  output xlatStrobe_t         strobe
);
  logic modeLegal;

  generate
    if (PAGED_EN) begin : g_paged
      assign modeLegal = 1'b1;
    end else begin : g_bare
      assign modeLegal = ~wrMode;
    end
  endgenerate

  always_comb begin
    strobe.load = csrWrEn & modeLegal;
    strobe.chg  = strobe.load & ((wrMode != curMode) | (wrAsidLegal != curAsidQ));
  end
endmodule

// File: rtl/xlat_ctrl_dp.sv
module xlat_ctrl_dp
  import xlat_ctrl_pkg::*;
#(
  parameter int ASID_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         csrWrData,
  input  xlatStrobe_t         strobe,
  input  logic [1:0]          privLvl,
  output logic                wrMode,
  output logic [ASID_MAX-1:0] wrAsidLegal,
  output logic                curMode,
  output logic [ASID_MAX-1:0] curAsidQ,
  output logic [PPN_W-1:0]    ppnQ,
  output logic                xlatEn,
  output logic                chgQ
);
  localparam logic [ASID_MAX-1:0] ASID_MASK = ASID_MAX'((1 << ASID_W) - 1);

  assign wrMode      = csrWrData[MODE_BIT];
  assign wrAsidLegal = csrWrData[ASID_LSB +: ASID_MAX] & ASID_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode <= 1'b0;
      ppnQ    <= '0;
      chgQ    <= 1'b0;
    end else begin
      chgQ <= strobe.chg;
      if (strobe.load) begin
        curMode <= wrMode;
        ppnQ    <= csrWrData[PPN_W-1:0];
      end
    end
  end

  generate
    if (ASID_W == 0) begin : g_noAsid
      assign curAsidQ = '0;
    end else begin : g_asid
      logic [ASID_W-1:0] asidQ;
      always_ff @(posedge clk) begin
        if (!rstN) asidQ <= '0;
        else if (strobe.load) asidQ <= wrAsidLegal[ASID_W-1:0];
      end
      assign curAsidQ = ASID_MAX'(asidQ);
    end
  endgenerate

  // Only user and supervisor levels translate.
  assign xlatEn = curMode & ((privLvl == 2'b00) | (privLvl == 2'b01));
endmodule

// File: rtl/xlat_ctrl_top.sv
module xlat_ctrl_top
  import xlat_ctrl_pkg::*;
#(
  parameter bit PAGED_EN = 1'b1,
  parameter int ASID_W   = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWrEn,
  input  logic [31:0] csrWrData,
  output logic [31:0] csrRdData,
  input  logic [1:0]  privLvl,
  output logic        xlatEn,
  output logic [8:0]  curAsid,
  output logic [21:0] rootPpn,
  output logic        ctxChgPulse
);
  xlatStrobe_t         strobe;
  logic                wrMode;
  logic                curMode;
  logic [ASID_MAX-1:0] wrAsidLegal;
  logic [ASID_MAX-1:0] curAsidQ;
  logic [PPN_W-1:0]    ppnQ;

  xlat_ctrl_ctl #(.PAGED_EN(PAGED_EN)) ctlI (
    .csrWrEn(csrWrEn), .wrMode(wrMode), .wrAsidLegal(wrAsidLegal),
    .curMode(curMode), .curAsidQ(curAsidQ), .strobe(strobe)
  );

  xlat_ctrl_dp #(.ASID_W(ASID_W)) dpI (
    .clk(clk), .rstN(rstN), .csrWrData(csrWrData), .strobe(strobe),
    .privLvl(privLvl), .wrMode(wrMode), .wrAsidLegal(wrAsidLegal),
    .curMode(curMode), .curAsidQ(curAsidQ), .ppnQ(ppnQ),
    .xlatEn(xlatEn), .chgQ(ctxChgPulse)
  );

  assign csrRdData = {curMode, curAsidQ, ppnQ};
  assign curAsid   = curAsidQ;
  assign rootPpn   = ppnQ;
endmodule

// File: rtl/xlat_ctrl_chk.sv
module xlat_ctrl_chk #(
  parameter bit PAGED_EN = 1'b1,
  parameter int ASID_W   = 9
) (
  input logic        clk,
  input logic        rstN,
  input logic        csrWrEn,
  input logic [31:0] csrWrData,
  input logic [31:0] csrRdData,
  input logic [1:0]  privLvl,
  input logic        xlatEn,
  input logic [8:0]  curAsid,
  input logic [21:0] rootPpn,
  input logic        ctxChgPulse
);
  localparam logic [8:0] UNIMPL = ~9'((1 << ASID_W) - 1);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> $stable(csrRdData));

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdData[30:22] & UNIMPL) == 9'd0);

  p_no_bad_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    !PAGED_EN |-> !csrRdData[31]);

  p_bad_write_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!PAGED_EN && csrWrEn && csrWrData[31]) |=> $stable(csrRdData));

  p_machine_untranslated_r2: assert property (@(posedge clk) disable iff (!rstN)
    privLvl[1] |-> !xlatEn);

  p_outputs_track_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curAsid == csrRdData[30:22]) && (rootPpn == csrRdData[21:0]));

  p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctxChgPulse == ((curAsid != $past(curAsid)) || (csrRdData[31] != $past(csrRdData[31]))));
endmodule

bind xlat_ctrl_top xlat_ctrl_chk #(.PAGED_EN(PAGED_EN), .ASID_W(ASID_W)) chkI (.*);

// File: tb/xlat_ctrl_top_test.sv
module xlat_ctrl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW_A = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [1:0] privLvl = 2'b01;

  logic [31:0] rdA, rdB;
  logic xlatA, xlatB, pulseA, pulseB;
  logic [8:0] asidA, asidB;
  logic [21:0] ppnA, ppnB;

  int nChecks = 0;
  int nFails = 0;

  // Bench model state for both builds
  logic [31:0] expA = '0, expB = '0;
  logic expPulseA = 1'b0, expPulseB = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctrl_top #(.PAGED_EN(1'b1), .ASID_W(AW_A)) uut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rdA), .privLvl(privLvl), .xlatEn(xlatA), .curAsid(asidA),
    .rootPpn(ppnA), .ctxChgPulse(pulseA));

  xlat_ctrl_top #(.PAGED_EN(1'b0), .ASID_W(0)) uutBare (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rdB), .privLvl(privLvl), .xlatEn(xlatB), .curAsid(asidB),
    .rootPpn(ppnB), .ctxChgPulse(pulseB));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] legalize(input logic [31:0] d, input bit paged, input int aw,
                                           input logic [31:0] old);
    logic [8:0] m;
    m = 9'((1 << aw) - 1);
    if (d[31] && !paged) return old;
    return {d[31], d[30:22] & m, d[21:0]};
  endfunction

  // Write on the falling edge; the design commits at the next rising edge and
  // is sampled at the falling edge after that.
  task automatic doWrite(input logic [31:0] d);
    logic [31:0] nA, nB;
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = d;
    nA = legalize(d, 1'b1, AW_A, expA);
    nB = legalize(d, 1'b0, 0, expB);
    expPulseA = (nA[31:22] != expA[31:22]);
    expPulseB = (nB[31:22] != expB[31:22]);
    expA = nA; expB = nB;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic checkState(input string req);
    check(req, rdA, expA);
    check(req, rdB, expB);
    check({req, "_out"}, {1'b0, asidA, ppnA}, {1'b0, expA[30:22], expA[21:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8", rdA, 32'h0);
    check("R8", rdB, 32'h0);
    check("R8", {30'd0, xlatA, pulseA}, 32'h0);

    // R1 field placement and R4 width sweep over every ASID value
    for (int a = 0; a < 512; a++) begin
      doWrite({a[0], a[8:0], 22'(a * 7919)});
      checkState("R1_R4");
      check("R6", {31'd0, pulseA}, {31'd0, expPulseA});
      check("R6", {31'd0, pulseB}, {31'd0, expPulseB});
    end

    // R4 discovery: write ones, read back width
    doWrite(32'h7FC0_0000);
    check("R4", {23'd0, rdA[30:22]}, 32'h0000_000F);
    check("R4", {23'd0, rdB[30:22]}, 32'h0);

    // R7 hold with no write
    repeat (5) @(negedge clk);
    checkState("R7");
    check("R7", {30'd0, pulseA, pulseB}, 32'h0);

    // R3: paged request on the bare build drops PPN too
    doWrite(32'h0000_1234);
    doWrite(32'h8000_5678);
    check("R3", rdB, 32'h0000_1234);
    check("R3", rdA, 32'h8000_5678);
    check("R6", {30'd0, pulseA, pulseB}, 32'h2);

    // R6: PPN-only change and identical rewrite give no pulse
    doWrite(32'h8000_0001);
    check("R6", {31'd0, pulseA}, 32'h0);
    doWrite(32'h8000_0001);
    check("R6", {31'd0, pulseA}, 32'h0);
    @(negedge clk);
    check("R6", {31'd0, pulseA}, 32'h0);

    // R2 / R5: privilege sweep with mode set then cleared
    for (int m = 0; m < 2; m++) begin
      doWrite({m[0], 9'h005, 22'h3ABCD});
      for (int p = 0; p < 4; p++) begin
        privLvl = p[1:0];
        #1;
        check("R2_R5", {31'd0, xlatA}, {31'd0, (m == 1) && (p < 2)});
        check("R2", {31'd0, xlatB}, 32'h0);
      end
      privLvl = 2'b01;
      check("R5", {10'd0, ppnA}, 32'h3ABCD);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule